// File: doc/BRIEF.md
# Qualified Hold-and-Release Conversion Controller

This block sits in front of a converter core and governs when its decimation filter and modulator run. An active-low hold request arrives from outside, possibly shared by several converters on a common master clock. The request is first brought into the clock domain through a two-stage synchronizer. It then has to stay low for a minimum number of master clock cycles before it counts. Once qualified, the block holds the core in reset for as long as the request stays low. Configuration state lives outside this block and is never touched by it.

Release always happens on a master clock falling edge. Every device that samples the same rising request edge on the same clock therefore restarts sampling on the same edge. After release, an active-low ready output stays high until a fixed number of output-rate ticks has elapsed. That count is the settling time of the filter.

Two modes are offered. In continuous mode the core samples whenever it is not held. In launch mode the core stays idle until a qualified hold is released; that release starts one conversion, and sampling stops once the result is ready.

Top module: `conv_align_top`

## Requirements
- R1: After the asynchronous reset `rstN` is released, `coreRst` is 0 and `rdyN` is 1. `sampleEn` is 1 when `startMode` is 0 (continuous) and 0 when `startMode` is 1 (launch).
- R2: If `alignN` is sampled low on `MIN_LOW` (default 4) consecutive rising edges, it qualifies. `coreRst` then goes to 1 on the falling edge that follows the sixth rising edge after the first low sample: two synchronizer stages plus four width cycles.
- R3: A low pulse on `alignN` sampled on fewer than `MIN_LOW` rising edges is ignored entirely. `coreRst`, `sampleEn` and `rdyN` keep their values.
- R4: `coreRst` stays at 1 for as long as `alignN` stays low after qualification.
- R5: `coreRst` returns to 0 on the falling edge that follows the third rising edge after `alignN` is first sampled high.
- R6: While `coreRst` is 1, `sampleEn` is 0 and `rdyN` is 1. A qualified hold clears any settling progress, so the count restarts from zero after release.
- R7: `rdyN` falls right after the rising edge that samples the `SETTLE_TICKS`-th (default 4) `rateTick` pulse seen while `sampleEn` is 1. Ticks sampled while `sampleEn` is 0 are not counted.
- R8: In launch mode (`startMode` = 1), no sampling happens until the first qualified hold is released. After that release, `sampleEn` stays 1 until the settling count completes. It then drops to 0 in the same cycle that `rdyN` falls, and `rdyN` stays 0 until the next hold.
- R9: In continuous mode (`startMode` = 0), `sampleEn` stays 1 after settling and `rdyN` stays 0 until the next qualified hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; release is aligned to its falling edge |
| rstN | input | 1 | Asynchronous active-low block reset |
| alignN | input | 1 | Asynchronous active-low hold / launch request |
| startMode | input | 1 | 0 = continuous sampling, 1 = launch one conversion per release |
| rateTick | input | 1 | One-cycle pulse per output-data-rate period |
| coreRst | output | 1 | Reset to filter and modulator, high while held |
| sampleEn | output | 1 | Core may gather input samples |
| rdyN | output | 1 | Active-low ready, low once the filter has settled |

## Verification
Two functions can land on the same cycle: a rate tick and the edge on which a hold request becomes qualified. A tick can also arrive while the hold is still in force. The bench provokes both by raising `rateTick` on the edge where the hold is qualified, and again two cycles later while `coreRst` is high. It judges the outcome after release: `rdyN` must stay high through three fresh ticks and fall only on the fourth. That shows neither stray tick was counted and the hold restarted the settling count.

// File: rtl/conv_align_pkg.sv
package conv_align_pkg;

  // Strobes passed from the control half to the settling datapath.
  typedef struct packed {
    logic hold;     // qualified hold, rising-edge domain
    logic coreRst;  // hold retimed onto the falling edge
    logic armed;    // a qualified hold has been seen since reset
  } ctrl_strobe_t;

endpackage

// File: rtl/conv_align_sync.sv
module conv_align_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= RESET_VAL;
        else       chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= {STAGES{RESET_VAL}};
        else       chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/conv_align_ctrl.sv
module conv_align_ctrl
  import conv_align_pkg::*;
#(
  parameter int MIN_LOW = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         syncdN,
  output ctrl_strobe_t strobe
);

  localparam int CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] LastCnt = CW'(MIN_LOW - 1);

  logic [CW-1:0] lowCnt;
  logic          holdQ;
  logic          armedQ;
  logic          coreRstQ;

  // Width qualification on the synchronized request.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt <= '0;
      holdQ  <= 1'b0;
      armedQ <= 1'b0;
    end else if (syncdN) begin
      lowCnt <= '0;
      holdQ  <= 1'b0;
    end else if (!holdQ) begin
      if (lowCnt == LastCnt) begin
        holdQ  <= 1'b1;
        armedQ <= 1'b1;
      end else begin
        lowCnt <= lowCnt + 1'b1;
      end
    end
  end

  // Entry and release of the core reset land on the falling clock edge.
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) coreRstQ <= 1'b0;
    else       coreRstQ <= holdQ;
  end

  assign strobe = '{hold: holdQ, coreRst: coreRstQ, armed: armedQ};

  // Independent run-length observer for the width check.
  logic [CW-1:0] runLow;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       runLow <= '0;
    else if (syncdN)                 runLow <= '0;
    else if (runLow != CW'(MIN_LOW)) runLow <= runLow + 1'b1;
  end

  // R2: a hold only appears after MIN_LOW consecutive low samples
  a_r2_min_width: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdQ) |-> (runLow >= CW'(MIN_LOW)));

  // R4: once held, the hold persists while the request stays low
  a_r4_hold_while_low: assert property (@(posedge clk) disable iff (!rstN)
    (holdQ && !syncdN) |=> holdQ);

  // R5: the core reset is released only once the request is seen high
  a_r5_release_high: assert property (@(negedge clk) disable iff (!rstN)
    $fell(coreRstQ) |-> syncdN);

endmodule

// File: rtl/conv_align_settle.sv
module conv_align_settle
  import conv_align_pkg::*;
#(
  parameter int SETTLE_TICKS = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrl_strobe_t strobe,
  input  logic         startMode,
  input  logic         rateTick,
  output logic         sampleEn,
  output logic         rdyN
);

  localparam int CW = $clog2(SETTLE_TICKS + 1);
  localparam logic [CW-1:0] LastTick = CW'(SETTLE_TICKS - 1);

  logic [CW-1:0] tickCnt;
  logic          settledQ;
  logic          active;

  assign active = !strobe.coreRst &&
                  (!startMode || (strobe.armed && !settledQ));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt  <= '0;
      settledQ <= 1'b0;
    end else if (strobe.hold) begin
      tickCnt  <= '0;
      settledQ <= 1'b0;
    end else if (active && rateTick && !settledQ) begin
      if (tickCnt == LastTick) begin
        settledQ <= 1'b1;
        tickCnt  <= '0;
      end else begin
        tickCnt <= tickCnt + 1'b1;
      end
    end
  end

  assign sampleEn = active;
  assign rdyN     = strobe.coreRst | !settledQ;

  // R6: a held core neither samples nor reports ready
  a_r6_reset_quiet: assert property (@(posedge clk) disable iff (!rstN)
    strobe.coreRst |-> (rdyN && !sampleEn));

  // R7: ready only falls right after a sampled rate tick
  a_r7_fall_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdyN) |-> $past(rateTick));

  // R8: in launch mode a finished conversion stops sampling
  a_r8_single_launch: assert property (@(posedge clk) disable iff (!rstN)
    (startMode && !rdyN) |-> !sampleEn);

endmodule

// File: rtl/conv_align_top.sv
module conv_align_top
  import conv_align_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int MIN_LOW      = 4,
  parameter int SETTLE_TICKS = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic alignN,
  input  logic startMode,
  input  logic rateTick,
  output logic coreRst,
  output logic sampleEn,
  output logic rdyN
);

  logic         syncdN;
  ctrl_strobe_t strobe;

  conv_align_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  (alignN),
    .dout (syncdN)
  );

  conv_align_ctrl #(.MIN_LOW(MIN_LOW)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .syncdN (syncdN),
    .strobe (strobe)
  );

  conv_align_settle #(.SETTLE_TICKS(SETTLE_TICKS)) u_settle (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .startMode (startMode),
    .rateTick  (rateTick),
    .sampleEn  (sampleEn),
    .rdyN      (rdyN)
  );

  assign coreRst = strobe.coreRst;

endmodule

// File: tb/conv_align_top_tb.sv
`timescale 1ns/1ps
module conv_align_top_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic alignN = 1'b1;
  logic startMode = 1'b0;
  logic rateTick = 1'b0;
  logic coreRst, sampleEn, rdyN;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    int    at;
    logic  cr;
    logic  se;
    logic  rdy;
    string req;
  } exp_t;

  exp_t expQ[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  conv_align_top u_dut (
    .clk(clk), .rstN(rstN), .alignN(alignN), .startMode(startMode),
    .rateTick(rateTick), .coreRst(coreRst), .sampleEn(sampleEn), .rdyN(rdyN)
  );

  // Driver side: schedule an expected output triple for a given cycle.
  task automatic push(input int at, input logic cr, input logic se,
                      input logic rdy, input string req);
    exp_t e;
    e.at = at; e.cr = cr; e.se = se; e.rdy = rdy; e.req = req;
    expQ.push_back(e);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // Monitor: sample after the falling edge, compare due items.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      for (int i = expQ.size() - 1; i >= 0; i--) begin
        if (expQ[i].at == cyc) begin
          checks++;
          if (coreRst !== expQ[i].cr || sampleEn !== expQ[i].se ||
              rdyN !== expQ[i].rdy) begin
            failures++;
            $display("FAIL %s cyc=%0d actual cr=%b se=%b rdyN=%b expected cr=%b se=%b rdyN=%b",
                     expQ[i].req, cyc, coreRst, sampleEn, rdyN,
                     expQ[i].cr, expQ[i].se, expQ[i].rdy);
          end
          expQ.delete(i);
        end
      end
    end
  end

  initial begin
    int c;
    int m;
    // ---------------- continuous mode ----------------
    repeat (3) step();
    rstN = 1'b1;
    step();
    push(cyc, 1'b0, 1'b1, 1'b1, "R1");           // R1 reset state, continuous
    step();
    // R7/R9: four ticks settle; ready falls on the fourth
    for (int i = 1; i <= 4; i++) begin
      step(); rateTick = 1'b1;
      push(cyc + 1, 1'b0, 1'b1, (i < 4), "R7");
      step(); rateTick = 1'b0;
    end
    repeat (3) step();
    push(cyc, 1'b0, 1'b1, 1'b0, "R9");           // R9 stays sampling and ready
    // R3: three-cycle pulse is ignored
    step(); alignN = 1'b0; c = cyc;
    for (int k = 1; k <= 10; k++) push(c + k, 1'b0, 1'b1, 1'b0, "R3");
    repeat (3) step();
    alignN = 1'b1;
    repeat (10) step();
    // R2/R4/R6: ten-cycle pulse with ticks on the qualifying edge and while held
    step(); alignN = 1'b0; c = cyc;
    push(c + 5, 1'b0, 1'b1, 1'b0, "R2");
    push(c + 6, 1'b1, 1'b0, 1'b1, "R2");
    push(c + 9, 1'b1, 1'b0, 1'b1, "R4");
    push(c + 10, 1'b1, 1'b0, 1'b1, "R6");
    for (int k = 1; k <= 10; k++) begin
      step();
      rateTick = (k == 5 || k == 7);
      if (k == 10) alignN = 1'b1;
    end
    m = cyc;
    push(m + 2, 1'b1, 1'b0, 1'b1, "R5");
    push(m + 3, 1'b0, 1'b1, 1'b1, "R5");
    repeat (3) step();
    // R6/R7: count restarts from zero after release
    for (int i = 1; i <= 4; i++) begin
      step(); rateTick = 1'b1;
      push(cyc + 1, 1'b0, 1'b1, (i < 4), "R6");
      step(); rateTick = 1'b0;
    end
    repeat (4) step();
    // ---------------- launch mode ----------------
    rstN = 1'b0; startMode = 1'b1;
    repeat (2) step();
    rstN = 1'b1;
    step();
    push(cyc, 1'b0, 1'b0, 1'b1, "R1");           // R1 reset state, launch
    // R8: ticks before any launch do nothing
    for (int i = 1; i <= 4; i++) begin
      step(); rateTick = 1'b1;
      push(cyc + 1, 1'b0, 1'b0, 1'b1, "R8");
      step(); rateTick = 1'b0;
    end
    step(); alignN = 1'b0; c = cyc;
    push(c + 6, 1'b1, 1'b0, 1'b1, "R2");
    repeat (5) step();
    alignN = 1'b1; m = cyc;
    push(m + 3, 1'b0, 1'b1, 1'b1, "R8");
    repeat (3) step();
    for (int i = 1; i <= 4; i++) begin
      step(); rateTick = 1'b1;
      push(cyc + 1, 1'b0, (i < 4), (i < 4), "R8");
      step(); rateTick = 1'b0;
    end
    push(cyc + 3, 1'b0, 1'b0, 1'b0, "R8");
    repeat (6) step();
    if (expQ.size() != 0) begin
      checks++;
      failures++;
      $display("FAIL scoreboard actual pending=%0d expected pending=0", expQ.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule